// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

A purely combinational datapath slice for a 64-bit integer core. Each cycle it looks at one 32-bit instruction word, the first source operand and the current contents of the destination register. When the word belongs to its group, it returns either a right-justified field pulled out of the source, or the destination with a contiguous range of bits replaced by the low bits of the source. Eight forms are covered: one word-sized extract, one word-sized insert, and three double-word variants of each. In the double-word variants, fixed offsets of 32 on the position or size fields let 5-bit fields span the full 64-bit range.

The unit produces a result, a write strobe and an illegal-instruction flag. Register reads, forwarding and trap entry stay with the surrounding pipeline. A word that is not in the group leaves all three outputs at zero. A double-word form issued while 64-bit operation is disabled, or an undefined function code inside the group, sets the illegal flag instead of the write strobe.

Top module: `bitfield_unit`

## Requirements
- R1: When insn[31:26] is not 6'b011111, wr_en and illegal are 0 and result is 0.
- R2: Fields are rs at insn[25:21], rt at insn[20:16], upper field A at insn[15:11], lower field B at insn[10:6] and function code at insn[5:0]. Function 0 (word extract) returns bits B+A..B of rs_val[31:0], right-justified and sign-extended from bit 31.
- R3: Function 3 (double extract) returns A+1 bits of rs_val starting at bit B, right-justified, with the upper bits zero.
- R4: Function 1 (double extract, long) returns A+33 bits of rs_val starting at bit B, zero above.
- R5: Function 2 (double extract, upper) returns A+1 bits of rs_val starting at bit B+32, zero above.
- R6: In an extract, bits of the field that lie above bit 31 (word form) or above bit 63 (double forms) read as zero.
- R7: Function 4 (word insert) and function 7 (double insert) replace bits A..B of rt_val with rs_val shifted left by B and keep all other bits. The word insert then sign-extends bit 31 of that result.
- R8: Function 5 uses A+32 as the upper bound. Function 6 uses B+32 and A+32 as the bounds and B+32 as the shift.
- R9: An insert whose lower bound exceeds its upper bound returns rt_val unchanged in all 64 bits, with wr_en high.
- R10: Functions 1, 2, 3, 5, 6 and 7 with wide_en low set illegal, clear wr_en and give result 0. Functions 0 and 4 do not depend on wide_en.
- R11: Under the major opcode, function codes 8 to 63 set illegal, clear wr_en and give result 0.
- R12: wr_en and illegal are never high together, and result is 0 whenever wr_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word |
| rs_val | input | 64 | Source operand |
| rt_val | input | 64 | Current destination value (insert base) |
| wide_en | input | 1 | 64-bit operations enabled |
| result | output | 64 | Value to write to the destination |
| wr_en | output | 1 | Destination write strobe |
| illegal | output | 1 | Illegal-instruction indication |

## Verification
Directed words place fields at bit 0, straddling bit 31, and at the top of the word, so that errors in right-justification, sign extension and the +32 offsets each show up on their own. Fields that run past the source top separate zero fill from wrap-around or sign leakage. Inverted insert ranges on every insert form separate "keep rt" from "empty mask". Disabled wide mode and undefined codes then check the gating. A long run of random words follows, mostly inside the group, with random operands, compared against a bit-by-bit reference.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  localparam logic [5:0] MAJOR_OP = 6'b011111;

  typedef enum logic [2:0] {
    K_XW  = 3'd0,  // word extract
    K_XL  = 3'd1,  // double extract, long size
    K_XU  = 3'd2,  // double extract, upper position
    K_XD  = 3'd3,  // double extract
    K_IW  = 3'd4,  // word insert
    K_IL  = 3'd5,  // double insert, upper bound +32
    K_IU  = 3'd6,  // double insert, both bounds +32
    K_ID  = 3'd7   // double insert
  } bf_kind_e;
endpackage

// File: rtl/bitfield_decode.sv
module bitfield_decode
  import bitfield_pkg::*;
#(
  parameter int WLEN = 32,
  parameter int PW   = 7
) (
  input  logic [31:0]   insn,
  input  logic          wide_en,
  output logic [PW-1:0] lo,
  output logic [PW-1:0] hi,
  output logic          is_ins,
  output logic          is_word,
  output logic          wr_en,
  output logic          illegal
);
  localparam logic [PW-1:0] OFS = PW'(WLEN);

  logic          hit;
  logic          legal;
  bf_kind_e      kind;
  logic [PW-1:0] fa;
  logic [PW-1:0] fb;

  always_comb begin
    hit     = (insn[31:26] == MAJOR_OP);
    kind    = bf_kind_e'(insn[2:0]);
    fa      = PW'(insn[15:11]);
    fb      = PW'(insn[10:6]);
    is_ins  = insn[2];
    is_word = (insn[1:0] == 2'b00);
    legal   = (insn[5:3] == 3'b000) && (wide_en || is_word);
    wr_en   = hit && legal;
    illegal = hit && !legal;
    lo      = fb;
    hi      = fb + fa;
    unique case (kind)
      K_XW, K_XD: begin lo = fb;       hi = fb + fa;       end
      K_XL:       begin lo = fb;       hi = fb + fa + OFS; end
      K_XU:       begin lo = fb + OFS; hi = fb + fa + OFS; end
      K_IW, K_ID: begin lo = fb;       hi = fa;            end
      K_IL:       begin lo = fb;       hi = fa + OFS;      end
      K_IU:       begin lo = fb + OFS; hi = fa + OFS;      end
      default:    begin lo = fb;       hi = fa;            end
    endcase
  end

  always_comb begin
    if (insn[31:26] == MAJOR_OP && insn[5:3] == 3'b000 && !wide_en && insn[1:0] != 2'b00)
      p_wide_gate_r10: assert (!wr_en && illegal);
    if (insn[31:26] == MAJOR_OP && insn[5:3] != 3'b000)
      p_undef_code_r11: assert (illegal && !wr_en);
  end
endmodule

// File: rtl/bitfield_mask.sv
module bitfield_mask #(
  parameter int XLEN = 64,
  parameter int PW   = 7
) (
  input  logic [PW-1:0]   lo,
  input  logic [PW-1:0]   hi,
  output logic [XLEN-1:0] mask,
  output logic            valid
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign mask[i] = (PW'(i) >= lo) && (PW'(i) <= hi);
  end
  assign valid = (lo <= hi);

  always_comb begin
    if (valid && lo < PW'(XLEN))
      p_mask_span_r7: assert ($countones(mask) ==
        ((hi > PW'(XLEN-1) ? XLEN-1 : int'(hi)) - int'(lo) + 1));
  end
endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int PW   = 7
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] mask,
  input  logic [PW-1:0]   lo,
  input  logic            is_word,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] fld;

  always_comb begin
    src = is_word ? {{(XLEN-WLEN){1'b0}}, rs_val[WLEN-1:0]} : rs_val;
    fld = (src & mask) >> lo;
    res = is_word ? {{(XLEN-WLEN){fld[WLEN-1]}}, fld[WLEN-1:0]} : fld;
  end

  always_comb begin
    if (!is_word && lo < PW'(XLEN))
      p_field_inside_r3: assert (((res << lo) & ~mask) == '0);
  end
endmodule

// File: rtl/bitfield_insert.sv
module bitfield_insert #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int PW   = 7
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [XLEN-1:0] mask,
  input  logic [PW-1:0]   lo,
  input  logic            valid,
  input  logic            is_word,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] merged;

  always_comb begin
    shifted = rs_val << lo;
    merged  = rt_val ^ ((rt_val ^ shifted) & mask);
    if (!valid)
      res = rt_val;
    else if (is_word)
      res = {{(XLEN-WLEN){merged[WLEN-1]}}, merged[WLEN-1:0]};
    else
      res = merged;
  end

  always_comb begin
    if (valid && !is_word)
      p_keep_outside_r7: assert (((res ^ rt_val) & ~mask) == '0);
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic            wide_en,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic            illegal
);
  localparam int PW = $clog2(XLEN) + 1;

  logic [PW-1:0]   lo;
  logic [PW-1:0]   hi;
  logic            is_ins;
  logic            is_word;
  logic [XLEN-1:0] mask;
  logic            valid;
  logic [XLEN-1:0] ext_res;
  logic [XLEN-1:0] ins_res;

  bitfield_decode #(.WLEN(WLEN), .PW(PW)) u_dec (
    .insn(insn), .wide_en(wide_en), .lo(lo), .hi(hi),
    .is_ins(is_ins), .is_word(is_word), .wr_en(wr_en), .illegal(illegal)
  );

  bitfield_mask #(.XLEN(XLEN), .PW(PW)) u_mask (
    .lo(lo), .hi(hi), .mask(mask), .valid(valid)
  );

  bitfield_extract #(.XLEN(XLEN), .WLEN(WLEN), .PW(PW)) u_ext (
    .rs_val(rs_val), .mask(mask), .lo(lo), .is_word(is_word), .res(ext_res)
  );

  bitfield_insert #(.XLEN(XLEN), .WLEN(WLEN), .PW(PW)) u_ins (
    .rs_val(rs_val), .rt_val(rt_val), .mask(mask), .lo(lo),
    .valid(valid), .is_word(is_word), .res(ins_res)
  );

  always_comb begin
    if (!wr_en)
      result = '0;
    else if (is_ins)
      result = ins_res;
    else
      result = ext_res;
  end

  always_comb begin
    p_strobe_excl_r12: assert (!(wr_en && illegal));
    if (insn[31:26] != bitfield_pkg::MAJOR_OP)
      p_foreign_quiet_r1: assert (!wr_en && !illegal && result == '0);
    if (wr_en && is_ins && lo > hi)
      p_inverted_hold_r9: assert (result == rt_val);
  end
endmodule

// File: tb/bitfield_unit_tb.sv
module bitfield_unit_tb_top;
  logic        clk = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rt_val = '0;
  logic        wide_en = 1'b0;
  logic [63:0] result;
  logic        wr_en;
  logic        illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bitfield_unit dut_i (
    .insn(insn), .rs_val(rs_val), .rt_val(rt_val), .wide_en(wide_en),
    .result(result), .wr_en(wr_en), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input int fn, input int a, input int b);
    return {6'b011111, 5'd3, 5'd9, a[4:0], b[4:0], fn[5:0]};
  endfunction

  // Behavioural reference: returns {illegal, wr_en, result}
  function automatic logic [65:0] model(input logic [31:0] w, input logic [63:0] s,
                                        input logic [63:0] t, input logic we);
    int fn = int'(w[5:0]);
    int a  = int'(w[15:11]);
    int b  = int'(w[10:6]);
    logic [63:0] r = '0;
    if (w[31:26] != 6'b011111) return {1'b0, 1'b0, 64'd0};
    if (fn > 7) return {1'b1, 1'b0, 64'd0};
    if (fn != 0 && fn != 4 && !we) return {1'b1, 1'b0, 64'd0};
    if (fn < 4) begin
      int start = b + ((fn == 2) ? 32 : 0);
      int len   = a + 1 + ((fn == 1) ? 32 : 0);
      int top   = (fn == 0) ? 32 : 64;
      for (int i = 0; i < 64; i++)
        if (i < len && start + i < top) r[i] = s[start + i];
      if (fn == 0) for (int i = 32; i < 64; i++) r[i] = r[31];
    end else begin
      int l = b + ((fn == 6) ? 32 : 0);
      int h = a + ((fn == 5 || fn == 6) ? 32 : 0);
      r = t;
      if (l <= h) begin
        for (int i = l; i <= h; i++) r[i] = s[i - l];
        if (fn == 4) for (int i = 32; i < 64; i++) r[i] = r[31];
      end
    end
    return {1'b0, 1'b1, r};
  endfunction

  function automatic string tag(input logic [31:0] w, input logic we);
    int fn = int'(w[5:0]);
    int a  = int'(w[15:11]);
    int b  = int'(w[10:6]);
    if (w[31:26] != 6'b011111) return "R1";
    if (fn > 7) return "R11";
    if (fn != 0 && fn != 4 && !we) return "R10";
    if (fn == 0 && a + b > 31) return "R6";
    if (fn == 2 && a + b > 31) return "R6";
    if (fn == 1 && a + b > 31) return "R6";
    case (fn)
      0: return "R2";
      1: return "R4";
      2: return "R5";
      3: return "R3";
      4, 7: return (b > a) ? "R9" : "R7";
      default: return ((fn == 6 && b > a) || (fn == 5 && b > a + 32)) ? "R9" : "R8";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input logic [63:0] s,
                       input logic [63:0] t, input logic we);
    logic [65:0] exp;
    @(posedge clk);
    #1;
    insn = w; rs_val = s; rt_val = t; wide_en = we;
    @(negedge clk);
    exp = model(w, s, t, we);
    n_cmp++;
    if ({illegal, wr_en, result} !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%08h got ill=%0b we=%0b res=%016h exp ill=%0b we=%0b res=%016h",
               tag(w, we), w, illegal, wr_en, result, exp[65], exp[64], exp[63:0]);
    end
    n_cmp++;  // R12 invariant
    if ((wr_en && illegal) || (!wr_en && result != 64'd0)) begin
      n_bad++;
      $display("FAIL R12 got we=%0b ill=%0b res=%016h exp exclusive strobes, zero idle result",
               wr_en, illegal, result);
    end
  endtask

  localparam logic [63:0] PA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] PB = 64'hF0E1_D2C3_B4A5_9687;

  initial begin
    // reset-like idle state: all-zero inputs, R1
    apply(32'h0, 64'h0, 64'h0, 1'b0);
    apply({6'b000000, 20'h12345, 6'd3}, PA, PB, 1'b1);          // R1
    apply(mk(0, 7, 4), PA, PB, 1'b1);                           // R2
    apply(mk(0, 31, 0), PB, PA, 1'b0);                          // R2 sign ext
    apply(mk(0, 15, 24), PB, PA, 1'b1);                         // R6 word top
    apply(mk(3, 31, 32), PB, PA, 1'b1);                         // R3
    apply(mk(3, 0, 63), PB, PA, 1'b1);                          // R3 single bit
    apply(mk(1, 31, 0), PB, PA, 1'b1);                          // R4 full width
    apply(mk(1, 3, 8), PA, PB, 1'b1);                           // R4
    apply(mk(2, 7, 4), PA, PB, 1'b1);                           // R5
    apply(mk(2, 31, 31), PB, PA, 1'b1);                         // R6 double top
    apply(mk(4, 15, 8), PA, PB, 1'b1);                          // R7
    apply(mk(4, 31, 16), 64'h0000_0000_0000_8001, PA, 1'b0);    // R7 sign
    apply(mk(7, 31, 0), PB, PA, 1'b1);                          // R7 double
    apply(mk(5, 31, 0), PB, PA, 1'b1);                          // R8 full
    apply(mk(5, 10, 20), PA, PB, 1'b1);                         // R8
    apply(mk(6, 5, 2), PB, PA, 1'b1);                           // R8
    apply(mk(4, 3, 9), PA, PB, 1'b1);                           // R9 word, rt kept whole
    apply(mk(7, 3, 9), PA, PB, 1'b1);                           // R9
    apply(mk(6, 0, 1), PA, PB, 1'b1);                           // R9
    apply(mk(3, 7, 0), PA, PB, 1'b0);                           // R10
    apply(mk(7, 7, 0), PA, PB, 1'b0);                           // R10
    apply(mk(2, 7, 0), PA, PB, 1'b0);                           // R10
    apply(mk(8, 7, 0), PA, PB, 1'b1);                           // R11
    apply(mk(63, 7, 0), PA, PB, 1'b1);                          // R11
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 8 != 0) w[31:26] = 6'b011111;
      if (k % 16 != 1) w[5:3] = 3'b000;
      apply(w, {$urandom, $urandom}, {$urandom, $urandom}, (k % 7) != 0);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got hung run exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule